// File: doc/BRIEF.md
# Change-Detection Interrupt Controller

This block watches a group of byte-wide digital input ports and raises a level interrupt toward a host when selected bits change. Every bit has its own enable for rising transitions and its own enable for falling transitions. A global control byte turns each transition direction on or off, and it gates which latched conditions may reach the interrupt line.

The first qualifying transition sets an edge flag. A further qualifying transition that arrives while that flag is still set also sets an overflow flag, so the host can tell that it missed at least one event. The host reads a status byte and acknowledges events through a write-only clear byte. Edge and overflow can be cleared separately or together. Inputs are asynchronous to the block clock and pass through a two-stage synchronizer before the transition compare.

The host reaches everything through a single-cycle byte bus with a write strobe and a combinational read port. A 32-bit change mask is spread over four ports, one byte per port, with the least significant byte in the lowest port.

Top module: `chg_irq_ctrl`

## Requirements
- R1: After reset the status byte (0x02), the control byte (0x03), every per-port enable byte and `irq` read as zero.
- R2: Port p owns a rising-enable byte at 0x40+0x10*p+0x2 and a falling-enable byte at 0x40+0x10*p+0x3. Each reads back as last written, and bit b of port p guards `port_in[8*p+b]`.
- R3: A 0-to-1 change on an input bit whose rising enable is set, while control bit3 is set, sets status bit0. The bit is visible after the third rising clock edge that follows the input change.
- R4: A 1-to-0 change on an input bit whose falling enable is set, while control bit4 is set, sets status bit0 with the same latency as R3.
- R5: A change on a bit whose per-bit enable for that direction is clear, or whose direction is globally off (control bit3 or bit4 clear), leaves status bit0 unchanged.
- R6: A qualifying change that arrives while status bit0 is already set, and in a cycle with no edge-clear write, sets status bit1 (overflow).
- R7: Writing the clear byte (0x01) with bit0 set clears status bit0, and with bit2 set clears status bit1; both may be cleared in one write. If a qualifying change lands in the same cycle as the clear, the flag it sets stays set.
- R8: Status bit2 and `irq` are both equal to control bit2 AND ((status bit0 AND control bit0) OR (status bit1 AND control bit1)).
- R9: Writing 0x00 to the control byte drops `irq` on the next cycle, and no new event is latched while it stays zero.
- R10: Writes to unmapped addresses change no register, and reads from unmapped addresses return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| port_in | input | NUM_PORTS*PORT_W | Watched inputs, port p on bits [8p+7:8p] |
| bus_addr | input | ADDR_W | Register address |
| bus_wdata | input | PORT_W | Write data |
| bus_we | input | 1 | Write strobe, one write per cycle |
| bus_rdata | output | PORT_W | Read data for `bus_addr`, combinational |
| irq | output | 1 | Level interrupt to the host |

## Verification
The assertions assume that `port_in` changes no faster than the synchronizer can pass it and that at most one bus write occurs per cycle. The stimulus respects both by moving inputs and write strobes only on the falling clock edge. They also assume `rst_n` is held low for several cycles with the inputs at zero, so that the synchronizer and the previous-value stage start out in agreement. The random phase also keeps to the mapped addresses plus a few unmapped ones, so every transition the model predicts comes from a real input change.

// File: rtl/cdi_pkg.sv
package cdi_pkg;
  localparam int unsigned ADR_CLEAR   = 'h01;
  localparam int unsigned ADR_STATUS  = 'h02;
  localparam int unsigned ADR_CTRL    = 'h03;
  localparam int unsigned PORT_BASE   = 'h40;
  localparam int unsigned PORT_STRIDE = 'h10;
  localparam int unsigned OFS_RISE    = 'h2;
  localparam int unsigned OFS_FALL    = 'h3;

  // clear-byte command bits
  localparam int unsigned CLR_EDGE_BIT = 0;
  localparam int unsigned CLR_OVF_BIT  = 2;

  // control byte, LSB is the edge interrupt enable
  typedef struct packed {
    logic fall_on;
    logic rise_on;
    logic master;
    logic ovf_ie;
    logic edge_ie;
  } ctrl_t;

  localparam int unsigned CTRL_W = $bits(ctrl_t);

  function automatic int unsigned port_reg_addr(input int unsigned p, input int unsigned ofs);
    return PORT_BASE + p * PORT_STRIDE + ofs;
  endfunction

  function automatic logic [7:0] rise_bits(input logic [7:0] cur, input logic [7:0] old,
                                           input logic [7:0] en);
    return cur & ~old & en;
  endfunction

  function automatic logic [7:0] fall_bits(input logic [7:0] cur, input logic [7:0] old,
                                           input logic [7:0] en);
    return ~cur & old & en;
  endfunction
endpackage

// File: rtl/cdi_sync.sv
module cdi_sync #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);
  logic [WIDTH-1:0] stage1_q;
  logic [WIDTH-1:0] stage2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= '0;
      stage2_q <= '0;
    end else begin
      stage1_q <= async_in;
      stage2_q <= stage1_q;
    end
  end

  assign sync_out = stage2_q;
endmodule

// File: rtl/cdi_edge_detect.sv
module cdi_edge_detect
  import cdi_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] din_sync,
  input  logic [WIDTH-1:0] rise_mask,
  input  logic [WIDTH-1:0] fall_mask,
  input  logic             rise_on,
  input  logic             fall_on,
  output logic             hit
);
  logic [WIDTH-1:0] prev_q;
  logic [WIDTH-1:0] rise_ev;
  logic [WIDTH-1:0] fall_ev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= din_sync;
  end

  always_comb begin
    rise_ev = WIDTH'(rise_bits(8'(din_sync), 8'(prev_q), 8'(rise_mask)));
    fall_ev = WIDTH'(fall_bits(8'(din_sync), 8'(prev_q), 8'(fall_mask)));
    if (!rise_on) rise_ev = '0;
    if (!fall_on) fall_ev = '0;
  end

  assign hit = |{rise_ev, fall_ev};

  // R5: with both directions globally off, nothing is reported
  a_r5_quiet_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    (!rise_on && !fall_on) |-> !hit);
  // R5: a stable input never reports
  a_r5_stable_no_hit: assert property (@(posedge clk) disable iff (!rst_n)
    (din_sync == prev_q) |-> !hit);
endmodule

// File: rtl/cdi_event_latch.sv
module cdi_event_latch
  import cdi_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  hit_any,
  input  logic  clr_edge,
  input  logic  clr_ovf,
  input  ctrl_t ctrl,
  output logic  edge_flag,
  output logic  ovf_flag,
  output logic  master_pend
);
  logic ovf_set;

  assign ovf_set = hit_any && edge_flag && !clr_edge;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      edge_flag <= 1'b0;
      ovf_flag  <= 1'b0;
    end else begin
      if (hit_any)       edge_flag <= 1'b1;
      else if (clr_edge) edge_flag <= 1'b0;
      if (ovf_set)       ovf_flag <= 1'b1;
      else if (clr_ovf)  ovf_flag <= 1'b0;
    end
  end

  always_comb begin
    master_pend = (edge_flag && ctrl.edge_ie) || (ovf_flag && ctrl.ovf_ie);
    if (!ctrl.master) master_pend = 1'b0;
  end

  // R3 / R4: any qualifying change is latched on the next edge
  a_r3_edge_latched: assert property (@(posedge clk) disable iff (!rst_n)
    hit_any |=> edge_flag);
  // R6: a second change on a set flag produces overflow
  a_r6_second_edge_overflows: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_any && edge_flag && !clr_edge) |=> ovf_flag);
  // R7: a plain edge clear with no new change empties the flag
  a_r7_edge_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_edge && !hit_any) |=> !edge_flag);
  // R7: overflow clear with no new overflow empties it
  a_r7_ovf_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_ovf && !(hit_any && edge_flag && !clr_edge)) |=> !ovf_flag);
  // R6: overflow can only rise while an edge is already held
  a_r6_ovf_needs_edge: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf_flag) |-> $past(edge_flag));
  // R8: an enabled edge flag under master enable must request service
  a_r8_edge_requests: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_flag && ctrl.edge_ie && ctrl.master) |-> master_pend);
endmodule

// File: rtl/chg_irq_ctrl.sv
module chg_irq_ctrl
  import cdi_pkg::*;
#(
  parameter int NUM_PORTS = 4,
  parameter int PORT_W    = 8,
  parameter int ADDR_W    = 8
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [NUM_PORTS*PORT_W-1:0] port_in,
  input  logic [ADDR_W-1:0]           bus_addr,
  input  logic [PORT_W-1:0]           bus_wdata,
  input  logic                        bus_we,
  output logic [PORT_W-1:0]           bus_rdata,
  output logic                        irq
);
  localparam int IN_W = NUM_PORTS * PORT_W;

  ctrl_t             ctrl_q;
  logic [PORT_W-1:0] rise_en_q [NUM_PORTS];
  logic [PORT_W-1:0] fall_en_q [NUM_PORTS];
  logic [IN_W-1:0]   in_sync;
  logic [NUM_PORTS-1:0] port_hit;
  logic              hit_any;
  logic              sel_clear, sel_ctrl;
  logic              clr_edge, clr_ovf;
  logic              edge_flag, ovf_flag, master_pend;

  assign sel_clear = bus_we && (bus_addr == ADDR_W'(ADR_CLEAR));
  assign sel_ctrl  = bus_we && (bus_addr == ADDR_W'(ADR_CTRL));
  assign clr_edge  = sel_clear && bus_wdata[CLR_EDGE_BIT];
  assign clr_ovf   = sel_clear && bus_wdata[CLR_OVF_BIT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        ctrl_q <= '0;
    else if (sel_ctrl) ctrl_q <= ctrl_t'(bus_wdata[CTRL_W-1:0]);
  end

  cdi_sync #(.WIDTH(IN_W)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in (port_in),
    .sync_out (in_sync)
  );

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    logic wr_rise, wr_fall;
    assign wr_rise = bus_we && (bus_addr == ADDR_W'(port_reg_addr(p, OFS_RISE)));
    assign wr_fall = bus_we && (bus_addr == ADDR_W'(port_reg_addr(p, OFS_FALL)));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        rise_en_q[p] <= '0;
        fall_en_q[p] <= '0;
      end else begin
        if (wr_rise) rise_en_q[p] <= bus_wdata;
        if (wr_fall) fall_en_q[p] <= bus_wdata;
      end
    end

    cdi_edge_detect #(.WIDTH(PORT_W)) u_det (
      .clk       (clk),
      .rst_n     (rst_n),
      .din_sync  (in_sync[p*PORT_W +: PORT_W]),
      .rise_mask (rise_en_q[p]),
      .fall_mask (fall_en_q[p]),
      .rise_on   (ctrl_q.rise_on),
      .fall_on   (ctrl_q.fall_on),
      .hit       (port_hit[p])
    );
  end

  assign hit_any = |port_hit;

  cdi_event_latch u_latch (
    .clk         (clk),
    .rst_n       (rst_n),
    .hit_any     (hit_any),
    .clr_edge    (clr_edge),
    .clr_ovf     (clr_ovf),
    .ctrl        (ctrl_q),
    .edge_flag   (edge_flag),
    .ovf_flag    (ovf_flag),
    .master_pend (master_pend)
  );

  assign irq = master_pend;

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == ADDR_W'(ADR_STATUS))
      bus_rdata = PORT_W'({master_pend, ovf_flag, edge_flag});
    else if (bus_addr == ADDR_W'(ADR_CTRL))
      bus_rdata = PORT_W'(ctrl_q);
    for (int p = 0; p < NUM_PORTS; p++) begin
      if (bus_addr == ADDR_W'(port_reg_addr(p, OFS_RISE))) bus_rdata = rise_en_q[p];
      if (bus_addr == ADDR_W'(port_reg_addr(p, OFS_FALL))) bus_rdata = fall_en_q[p];
    end
  end

  // R8: interrupt never fires without master enable
  a_r8_irq_needs_master: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ctrl_q.master);
  // R9: cancelling drops the interrupt next cycle
  a_r9_cancel_quiets_irq: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_ctrl && bus_wdata == '0) |=> !irq);
  // R9: with everything off no edge flag rises
  a_r9_no_new_event: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q == '0) |=> !$rose(edge_flag));
endmodule

// File: tb/chg_irq_ctrl_test.sv
module chg_irq_ctrl_test;
  localparam int NP = 4;
  localparam int W  = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NP*W-1:0] port_in = '0;
  logic [7:0]    bus_addr = '0;
  logic [7:0]    bus_wdata = '0;
  logic          bus_we = 1'b0;
  logic [7:0]    bus_rdata;
  logic          irq;

  int checks = 0;
  int errors = 0;
  string cur_req = "R1";

  always #10 clk = ~clk;

  chg_irq_ctrl #(.NUM_PORTS(NP), .PORT_W(W), .ADDR_W(8)) uut (
    .clk(clk), .rst_n(rst_n), .port_in(port_in), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_we(bus_we), .bus_rdata(bus_rdata), .irq(irq)
  );

  // behavioural reference
  int          m_rise [NP];
  int          m_fall [NP];
  int          m_ctrl;
  bit          m_edge, m_ovf;
  logic [NP*W-1:0] hist [$];

  function automatic bit m_irq();
    bit pend;
    pend = (m_edge && m_ctrl[0]) || (m_ovf && m_ctrl[1]);
    return pend && m_ctrl[2];
  endfunction

  function automatic int m_read(int a);
    if (a == 2) return {m_irq(), m_ovf, m_edge};
    if (a == 3) return m_ctrl;
    for (int p = 0; p < NP; p++) begin
      if (a == 'h42 + 16 * p) return m_rise[p];
      if (a == 'h43 + 16 * p) return m_fall[p];
    end
    return 0;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int p = 0; p < NP; p++) begin m_rise[p] = 0; m_fall[p] = 0; end
      m_ctrl = 0; m_edge = 0; m_ovf = 0;
      hist = '{'0, '0, '0};
    end else begin
      bit hit, ce, co, ovf_n, edge_n;
      hit = 0;
      for (int p = 0; p < NP; p++) begin
        for (int b = 0; b < W; b++) begin
          bit now_v, was_v;
          now_v = hist[1][p*W+b];
          was_v = hist[2][p*W+b];
          if (now_v && !was_v && m_rise[p][b] && m_ctrl[3]) hit = 1;
          if (!now_v && was_v && m_fall[p][b] && m_ctrl[4]) hit = 1;
        end
      end
      ce = bus_we && bus_addr == 8'h01 && bus_wdata[0];
      co = bus_we && bus_addr == 8'h01 && bus_wdata[2];
      ovf_n  = (hit && m_edge && !ce) ? 1'b1 : (co ? 1'b0 : m_ovf);
      edge_n = hit ? 1'b1 : (ce ? 1'b0 : m_edge);
      m_ovf = ovf_n; m_edge = edge_n;
      if (bus_we) begin
        if (bus_addr == 8'h03) m_ctrl = bus_wdata & 8'h1F;
        for (int p = 0; p < NP; p++) begin
          if (bus_addr == 8'(8'h42 + 16 * p)) m_rise[p] = bus_wdata;
          if (bus_addr == 8'(8'h43 + 16 * p)) m_fall[p] = bus_wdata;
        end
      end
      hist.push_front(port_in);
      void'(hist.pop_back());
    end
  end

  // cycle-by-cycle comparison, sampled away from the clock edge
  always @(posedge clk) begin
    #5;
    if (rst_n) begin
      checks++;
      if (irq !== m_irq() || bus_rdata !== 8'(m_read(bus_addr))) begin
        errors++;
        $display("FAIL %s model: addr %02h rdata %02h irq %0b expected rdata %02h irq %0b",
                 cur_req, bus_addr, bus_rdata, irq, 8'(m_read(bus_addr)), m_irq());
      end
    end
  end

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk); bus_we = 1'b0;
  endtask

  task automatic expect_rd(input logic [7:0] a, input logic [7:0] exp, input string req);
    @(negedge clk); bus_addr = a; #2;
    checks++;
    if (bus_rdata !== exp) begin
      errors++;
      $display("FAIL %s read %02h: got %02h expected %02h", req, a, bus_rdata, exp);
    end
  endtask

  task automatic expect_irq(input logic exp, input string req);
    @(negedge clk); #2;
    checks++;
    if (irq !== exp) begin
      errors++;
      $display("FAIL %s irq: got %0b expected %0b", req, irq, exp);
    end
  endtask

  task automatic drive(input logic [NP*W-1:0] v);
    @(negedge clk); port_in = v;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not finish, got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    cur_req = "R1";
    expect_rd(8'h02, 8'h00, "R1");
    expect_rd(8'h03, 8'h00, "R1");
    expect_rd(8'h42, 8'h00, "R1");
    expect_rd(8'h73, 8'h00, "R1");
    expect_irq(1'b0, "R1");
    // R2 mask spread over four ports, LSB in port 0
    cur_req = "R2";
    wr(8'h42, 8'h81); wr(8'h52, 8'h0F); wr(8'h62, 8'hC3); wr(8'h72, 8'hA5);
    wr(8'h43, 8'h01);
    expect_rd(8'h42, 8'h81, "R2");
    expect_rd(8'h52, 8'h0F, "R2");
    expect_rd(8'h62, 8'hC3, "R2");
    expect_rd(8'h72, 8'hA5, "R2");
    expect_rd(8'h43, 8'h01, "R2");
    // R10 unmapped
    cur_req = "R10";
    wr(8'h44, 8'hFF); wr(8'h05, 8'hFF);
    expect_rd(8'h44, 8'h00, "R10");
    expect_rd(8'h05, 8'h00, "R10");
    expect_rd(8'h42, 8'h81, "R10");
    // R3 rising edge
    cur_req = "R3";
    wr(8'h03, 8'h1D);
    drive(32'h1);
    expect_rd(8'h02, 8'h05, "R3");
    expect_irq(1'b1, "R8");
    cur_req = "R7";
    wr(8'h01, 8'h01);
    expect_rd(8'h02, 8'h00, "R7");
    // R4 falling edge
    cur_req = "R4";
    drive(32'h0);
    expect_rd(8'h02, 8'h05, "R4");
    wr(8'h01, 8'h01);
    // R5 per-bit disabled
    cur_req = "R5";
    drive(32'h2);
    expect_rd(8'h02, 8'h00, "R5");
    drive(32'h0);
    // R5 rising globally off; falling still on
    wr(8'h03, 8'h15);
    drive(32'h1);
    expect_rd(8'h02, 8'h00, "R5");
    drive(32'h0);
    expect_rd(8'h02, 8'h05, "R4");
    wr(8'h01, 8'h01);
    // R6 overflow
    cur_req = "R6";
    wr(8'h03, 8'h1F);
    drive(32'h1);
    drive(32'h0);
    expect_rd(8'h02, 8'h07, "R6");
    cur_req = "R8";
    wr(8'h01, 8'h01);
    expect_rd(8'h02, 8'h06, "R8");
    wr(8'h03, 8'h1D);
    expect_rd(8'h02, 8'h02, "R8");
    expect_irq(1'b0, "R8");
    cur_req = "R7";
    wr(8'h01, 8'h04);
    expect_rd(8'h02, 8'h00, "R7");
    // R2 port 3 bit 0 guards input bit 24
    cur_req = "R2";
    drive(32'h0100_0000);
    expect_rd(8'h02, 8'h05, "R2");
    wr(8'h01, 8'h05);
    drive(32'h0);
    wr(8'h01, 8'h05);
    // R9 cancel
    cur_req = "R9";
    wr(8'h03, 8'h1F);
    drive(32'h1);
    expect_irq(1'b1, "R9");
    wr(8'h03, 8'h00);
    expect_irq(1'b0, "R9");
    drive(32'h0);
    expect_rd(8'h02, 8'h01, "R9");
    wr(8'h01, 8'h05);
    expect_rd(8'h02, 8'h00, "R7");
    // random phase against the model (R6, R7 same-cycle cases)
    cur_req = "R6";
    for (int i = 0; i < 3000; i++) begin
      int sel;
      @(negedge clk);
      if ($urandom_range(0, 3) == 0) port_in = $urandom;
      sel = $urandom_range(0, 9);
      bus_we = ($urandom_range(0, 2) == 0);
      bus_wdata = 8'($urandom);
      case (sel)
        0, 1, 2: bus_addr = 8'h01;
        3:       begin bus_addr = 8'h03; bus_wdata = bus_wdata | 8'h18; end
        4:       bus_addr = 8'(8'h42 + 16 * $urandom_range(0, NP - 1));
        5:       bus_addr = 8'(8'h43 + 16 * $urandom_range(0, NP - 1));
        6:       bus_addr = 8'h02;
        7:       bus_addr = 8'h44;
        default: bus_addr = 8'h02;
      endcase
    end
    @(negedge clk); bus_we = 1'b0;
    repeat (4) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule